// File: doc/BRIEF.md
# Opcode fetch prefix tracker

This block watches a byte-wide processor memory bus without driving it. Using the active-low machine-cycle-one, memory-request and read strobes plus the 8-bit data bus, it sorts every memory read into one of four kinds: a plain opcode, an opcode that follows one or more prefix bytes, a displacement byte that sits between a two-byte index prefix and its final opcode, or an ordinary data read that is not part of a fetch.

After each qualifying read the block presents the prefix gathered so far (zero, one byte or two bytes in a 16-bit field), a 9-bit opcode code and an invalid flag. Code 0x100 tags the displacement byte. A combinational fetch-valid output is high while memory request and read are both low and the current code is valid. A trace viewer or on-chip debug logic uses these outputs to label bus activity.

Top module: `opfetch_tracker`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) prefix_out is 0x0000, opcode_out is 0x000, opcode_invalid is 1 and fetch_valid is 0, and the tracker is idle.
- R2: Outputs change only at a clock edge where rd_n is sampled low, rd_n was sampled high at the edge before, and mreq_n is low. Reads with mreq_n high, and rd_n held low across several edges, leave prefix_out, opcode_out and opcode_invalid unchanged.
- R3: In idle, a read with m1_n low gives prefix_out 0x0000, opcode_out equal to {1'b0, byte} and opcode_invalid 0.
- R4: In idle, a read with m1_n high gives prefix_out 0x0000, opcode_out 0x000 and opcode_invalid 1, and the tracker stays idle.
- R5: A fetched 0xCB or 0xED in idle makes the next read the final opcode: prefix_out becomes 0x00CB or 0x00ED, opcode_out the new byte, and the tracker returns to idle.
- R6: A fetched 0xDD or 0xFD enters an index state. Each following read sets prefix_out to {8'h00, previous byte} and opcode_out to the new byte. A further 0xDD or 0xFD stays in the index state, 0xCB moves to the displacement state, any other byte returns to idle.
- R7: The read in the displacement state sets prefix_out to {byte before 0xCB, 8'hCB} (0xDDCB or 0xFDCB), opcode_out to 0x100 and opcode_invalid to 0.
- R8: The read after the displacement sets opcode_out to the new byte, keeps prefix_out, and returns the tracker to idle.
- R9: fetch_valid is 1 exactly when mreq_n is 0, rd_n is 0 and opcode_invalid is 0.
- R10: Outside idle, the level of m1_n has no effect on how a read is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| m1_n | input | 1 | Active-low machine-cycle-one strobe |
| mreq_n | input | 1 | Active-low memory request strobe |
| rd_n | input | 1 | Active-low read strobe |
| data_in | input | 8 | Data bus byte |
| prefix_out | output | 16 | Prefix gathered for the current read |
| opcode_out | output | 9 | Opcode code; 0x100 marks a displacement byte |
| opcode_invalid | output | 1 | High when the last read was not part of a fetch |
| fetch_valid | output | 1 | High while a valid fetch read is on the bus |

## Verification
A wrong state shows on the very next qualifying read: a byte handled in the wrong state comes out with the wrong prefix, a missing 0x100 tag, or an invalid flag where a fetch is expected. A tracker stuck outside idle shows when a later M1-high read stays valid. The bench therefore follows each prefix chain with one more read that proves the return to idle. A missed or doubled strobe edge shows as outputs that change without a new read edge, or stay the same after one.

// File: rtl/opf_pkg.sv
// Shared widths, byte codes and state encoding for the opcode fetch tracker.
// Assumes a byte-wide data bus; the prefix holds up to two bytes.
package opf_pkg;
    localparam int BYTE_W = 8;
    localparam int PFX_W  = 2 * BYTE_W;
    localparam int CODE_W = BYTE_W + 1;

    localparam logic [BYTE_W-1:0] BYTE_CB = 8'hCB;
    localparam logic [BYTE_W-1:0] BYTE_ED = 8'hED;
    localparam logic [BYTE_W-1:0] BYTE_DD = 8'hDD;
    localparam logic [BYTE_W-1:0] BYTE_FD = 8'hFD;

    // Displacement tag: the one code above any byte value.
    localparam logic [CODE_W-1:0] CODE_DISP = {1'b1, {BYTE_W{1'b0}}};

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for the first byte of an instruction
        ST_TAIL  = 3'd1,  // after CB or ED, next byte is the opcode
        ST_INDEX = 3'd2,  // after DD or FD
        ST_DISP  = 3'd3,  // after DD/FD then CB, next byte is a displacement
        ST_FINAL = 3'd4   // after the displacement, next byte is the opcode
    } seq_state_t;
endpackage

// File: rtl/opf_edge.sv
// Read-strobe falling-edge detector.
// Registers rd_n on clk and raises adv for one cycle when rd_n goes low
// while mreq_n is low. Assumes strobes are already synchronous to clk.
module opf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic mreq_n,
    output logic adv
);
    logic rd_q;

    // Remember last sampled read strobe; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b1;
        else        rd_q <= rd_n;
    end

    // Qualified falling edge of the read strobe.
    always_comb adv = rd_q & ~rd_n & ~mreq_n;

    // A falling edge needs a high sample first, so it cannot repeat back to back.
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !adv);
endmodule

// File: rtl/opf_seq.sv
// Sequencer for the prefix / displacement / opcode walk.
// Moves only when adv is high; all other cycles hold the state.
module opf_seq
    import opf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              m1_n,
    input  logic [BYTE_W-1:0] data_in,
    output seq_state_t        state
);
    seq_state_t state_nxt;
    logic       is_tail_pfx;
    logic       is_index_pfx;

    // Classify the byte on the bus.
    always_comb begin
        is_tail_pfx  = (data_in == BYTE_CB) || (data_in == BYTE_ED);
        is_index_pfx = (data_in == BYTE_DD) || (data_in == BYTE_FD);
    end

    // Next state for a qualified read.
    always_comb begin
        state_nxt = state;
        if (adv) begin
            unique case (state)
                ST_IDLE: begin
                    if (!m1_n && is_tail_pfx)       state_nxt = ST_TAIL;
                    else if (!m1_n && is_index_pfx) state_nxt = ST_INDEX;
                    else                            state_nxt = ST_IDLE;
                end
                ST_TAIL:  state_nxt = ST_IDLE;
                ST_INDEX: begin
                    if (is_index_pfx)              state_nxt = ST_INDEX;
                    else if (data_in == BYTE_CB)   state_nxt = ST_DISP;
                    else                           state_nxt = ST_IDLE;
                end
                ST_DISP:  state_nxt = ST_FINAL;
                ST_FINAL: state_nxt = ST_IDLE;
                default:  state_nxt = ST_IDLE; // recovery from an illegal code
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // The displacement is always followed by the final opcode.
    p_final_after_disp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state == ST_DISP) |=> (state == ST_FINAL));

    // A non-fetch read in idle never leaves idle.
    p_nonfetch_stays_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state == ST_IDLE && m1_n) |=> (state == ST_IDLE));
endmodule

// File: rtl/opf_capture.sv
// Output registers for prefix, opcode code and invalid flag.
// Updates only on adv, choosing the new values by the current state.
module opf_capture
    import opf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              m1_n,
    input  logic [BYTE_W-1:0] data_in,
    input  seq_state_t        state,
    output logic [PFX_W-1:0]  prefix_q,
    output logic [CODE_W-1:0] code_q,
    output logic              invalid_q
);
    logic [PFX_W-1:0]  pfx_nxt;
    logic [CODE_W-1:0] code_nxt;
    logic              inv_nxt;
    logic [BYTE_W-1:0] prev_byte;

    // Low byte of the last captured code is the byte read before this one.
    always_comb prev_byte = code_q[BYTE_W-1:0];

    // New prefix, code and flag for a qualified read in each state.
    always_comb begin
        pfx_nxt  = prefix_q;
        code_nxt = code_q;
        inv_nxt  = invalid_q;
        unique case (state)
            ST_IDLE: begin
                pfx_nxt = '0;
                if (!m1_n) begin
                    code_nxt = {1'b0, data_in};
                    inv_nxt  = 1'b0;
                end else begin
                    code_nxt = '0;
                    inv_nxt  = 1'b1;
                end
            end
            ST_TAIL, ST_INDEX: begin
                pfx_nxt  = {{BYTE_W{1'b0}}, prev_byte};
                code_nxt = {1'b0, data_in};
                inv_nxt  = 1'b0;
            end
            ST_DISP: begin
                pfx_nxt  = {prefix_q[BYTE_W-1:0], prev_byte};
                code_nxt = CODE_DISP;
                inv_nxt  = 1'b0;
            end
            ST_FINAL: begin
                code_nxt = {1'b0, data_in};
                inv_nxt  = 1'b0;
            end
            default: begin
                pfx_nxt  = '0;
                code_nxt = '0;
                inv_nxt  = 1'b1;
            end
        endcase
    end

    // Output registers, written only on a qualified read edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prefix_q  <= '0;
            code_q    <= '0;
            invalid_q <= 1'b1;
        end else if (adv) begin
            prefix_q  <= pfx_nxt;
            code_q    <= code_nxt;
            invalid_q <= inv_nxt;
        end
    end

    // The displacement read always yields the tag code as a valid entry.
    p_disp_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state == ST_DISP) |=> (code_q == CODE_DISP && !invalid_q));

    // A two-byte prefix always ends in CB.
    p_long_prefix_cb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prefix_q[PFX_W-1:BYTE_W] != '0) |-> (prefix_q[BYTE_W-1:0] == BYTE_CB));
endmodule

// File: rtl/opfetch_tracker.sv
// Opcode fetch prefix tracker, top level.
// Passively watches memory reads and reports prefix, opcode code and an
// invalid flag per read, plus a live fetch-valid flag. Assumes all bus
// strobes are synchronous to clk and each read lasts at least one cycle.
module opfetch_tracker
    import opf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m1_n,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic [BYTE_W-1:0] data_in,
    output logic [PFX_W-1:0]  prefix_out,
    output logic [CODE_W-1:0] opcode_out,
    output logic              opcode_invalid,
    output logic              fetch_valid
);
    logic       adv;
    seq_state_t state;

    opf_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_n   (rd_n),
        .mreq_n (mreq_n),
        .adv    (adv)
    );

    opf_seq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .m1_n    (m1_n),
        .data_in (data_in),
        .state   (state)
    );

    opf_capture i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .m1_n      (m1_n),
        .data_in   (data_in),
        .state     (state),
        .prefix_q  (prefix_out),
        .code_q    (opcode_out),
        .invalid_q (opcode_invalid)
    );

    // Live fetch flag: bus is in a memory read and the code is meaningful.
    always_comb fetch_valid = ~mreq_n & ~rd_n & ~opcode_invalid;

    // Without an active memory read, the reported values hold.
    p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || mreq_n) |=> ($stable(prefix_out) && $stable(opcode_out)
                              && $stable(opcode_invalid)));

    // An invalid entry never carries a prefix.
    p_invalid_no_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        opcode_invalid |-> (prefix_out == '0));
endmodule

// File: tb/test_opfetch_tracker.sv
module test_opfetch_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m1_n = 1'b1;
    logic        mreq_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic [15:0] prefix_out;
    logic [8:0]  opcode_out;
    logic        opcode_invalid;
    logic        fetch_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opfetch_tracker i_opfetch_tracker (
        .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n),
        .data_in(data_in), .prefix_out(prefix_out), .opcode_out(opcode_out),
        .opcode_invalid(opcode_invalid), .fetch_valid(fetch_valid)
    );

    // Row: {m1_n, mreq_n, byte, exp prefix, exp code, exp invalid, exp fetch_valid}
    localparam logic [36:0] ROWS [NROWS] = '{
        {1'b0,1'b0,8'h3E,16'h0000,9'h03E,1'b0,1'b1},
        {1'b1,1'b0,8'h12,16'h0000,9'h000,1'b1,1'b0},
        {1'b0,1'b0,8'hCB,16'h0000,9'h0CB,1'b0,1'b1},
        {1'b0,1'b0,8'h47,16'h00CB,9'h047,1'b0,1'b1},
        {1'b1,1'b0,8'h55,16'h0000,9'h000,1'b1,1'b0},
        {1'b0,1'b0,8'hED,16'h0000,9'h0ED,1'b0,1'b1},
        {1'b1,1'b0,8'hB0,16'h00ED,9'h0B0,1'b0,1'b1},
        {1'b0,1'b0,8'hDD,16'h0000,9'h0DD,1'b0,1'b1},
        {1'b0,1'b0,8'h21,16'h00DD,9'h021,1'b0,1'b1},
        {1'b1,1'b0,8'hBC,16'h0000,9'h000,1'b1,1'b0},
        {1'b0,1'b0,8'hFD,16'h0000,9'h0FD,1'b0,1'b1},
        {1'b0,1'b0,8'hDD,16'h00FD,9'h0DD,1'b0,1'b1},
        {1'b0,1'b0,8'hFD,16'h00DD,9'h0FD,1'b0,1'b1},
        {1'b0,1'b0,8'hE5,16'h00FD,9'h0E5,1'b0,1'b1},
        {1'b1,1'b0,8'h00,16'h0000,9'h000,1'b1,1'b0},
        {1'b0,1'b0,8'hDD,16'h0000,9'h0DD,1'b0,1'b1},
        {1'b0,1'b0,8'hCB,16'h00DD,9'h0CB,1'b0,1'b1},
        {1'b1,1'b0,8'h05,16'hDDCB,9'h100,1'b0,1'b1},
        {1'b1,1'b0,8'hC6,16'hDDCB,9'h0C6,1'b0,1'b1},
        {1'b0,1'b0,8'h00,16'h0000,9'h000,1'b0,1'b1},
        {1'b0,1'b0,8'hFD,16'h0000,9'h0FD,1'b0,1'b1},
        {1'b0,1'b0,8'hFD,16'h00FD,9'h0FD,1'b0,1'b1},
        {1'b0,1'b0,8'hCB,16'h00FD,9'h0CB,1'b0,1'b1},
        {1'b0,1'b0,8'hFE,16'hFDCB,9'h100,1'b0,1'b1},
        {1'b1,1'b0,8'h4E,16'hFDCB,9'h04E,1'b0,1'b1},
        {1'b1,1'b1,8'h77,16'hFDCB,9'h04E,1'b0,1'b0},
        {1'b0,1'b0,8'hED,16'h0000,9'h0ED,1'b0,1'b1},
        {1'b0,1'b0,8'hED,16'h00ED,9'h0ED,1'b0,1'b1}
    };

    function automatic string row_tag(int i);
        case (i)
            0, 26:                           return "R3";
            1, 9, 14:                        return "R4";
            2, 3, 4, 5, 27:                  return "R5";
            6, 23:                           return "R10";
            7, 8, 10, 11, 12, 13, 15, 16,
            20, 21, 22:                      return "R6";
            17:                              return "R7";
            18, 19, 24:                      return "R8";
            default:                         return "R2";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One bus read: strobes drop at a falling clock edge and stay for one cycle.
    task automatic bus_read(logic m1, logic mreq, logic [7:0] b);
        @(negedge clk);
        m1_n = m1; mreq_n = mreq; data_in = b; rd_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_release();
        m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic chk_all(string tag, logic [15:0] p, logic [8:0] c, logic inv, logic fv);
        chk(tag, "prefix", 32'(prefix_out), 32'(p));
        chk(tag, "opcode", 32'(opcode_out), 32'(c));
        chk(tag, "invalid", 32'(opcode_invalid), 32'(inv));
        chk("R9", "fetch_valid", 32'(fetch_valid), 32'(fv));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values with the bus quiet
        chk_all("R1", 16'h0000, 9'h000, 1'b1, 1'b0);

        for (int i = 0; i < NROWS; i++) begin
            bus_read(ROWS[i][36], ROWS[i][35], ROWS[i][34:27]);
            chk_all(row_tag(i), ROWS[i][26:11], ROWS[i][10:2], ROWS[i][1], ROWS[i][0]);
            bus_release();
        end

        // R2: rd held low, new byte on the bus, no second capture
        bus_read(1'b0, 1'b0, 8'h3C);
        chk_all("R3", 16'h0000, 9'h03C, 1'b0, 1'b1);
        data_in = 8'hDD;
        repeat (3) @(negedge clk);
        chk_all("R2", 16'h0000, 9'h03C, 1'b0, 1'b1);
        bus_release();
        bus_read(1'b1, 1'b0, 8'h21);
        chk_all("R2", 16'h0000, 9'h000, 1'b1, 1'b0);
        bus_release();

        // R9: valid code but read strobe high, then read with mreq high
        bus_read(1'b0, 1'b0, 8'h00);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R9", "fetch_valid rd high", 32'(fetch_valid), 32'd0);
        chk("R9", "invalid kept", 32'(opcode_invalid), 32'd0);
        mreq_n = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        chk("R9", "fetch_valid mreq high", 32'(fetch_valid), 32'd0);
        bus_release();

        // R1: reset in the middle of an index prefix returns to idle
        bus_read(1'b0, 1'b0, 8'hDD);
        bus_release();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_all("R1", 16'h0000, 9'h000, 1'b1, 1'b0);
        bus_read(1'b1, 1'b0, 8'h21);
        chk_all("R1", 16'h0000, 9'h000, 1'b1, 1'b0);
        bus_release();

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule